// File: doc/BRIEF.md
# Preconditioning Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit with two data operands, `a_in` and `b_in`, and six independent control bits. It has no opcode decoder. Each operand passes through a clear stage and then an optional bitwise inversion. A core stage then either adds the two conditioned operands or ANDs them. A final stage can invert the core result.

Every supported operation comes from complement identities over these stages. This covers constants, negation, increment, decrement, differences and OR. The result drives two status flags: one for a zero result and one for a negative result. An arithmetic overflow is not flagged. The sum wraps and no carry leaves the block.

The control word is written as the six bits {clr_a, neg_a, clr_b, neg_b, add_sel, neg_res}, most significant first. A parameter selects the adder structure: a ripple chain or a parallel-prefix carry network. Both structures give identical results.

Top module: `precond_alu`

## Requirements
- R1: When `clr_a` is 1, operand A is replaced by zero before any later stage. `clr_b` does the same for operand B.
- R2: When `neg_a` is 1, the operand A that leaves the clear stage is bitwise inverted. `neg_b` does the same for operand B.
- R3: The clear stage acts before the inversion stage. With both clear and invert set on an operand, that operand becomes all ones (0xFFFF).
- R4: With `add_sel`=1, the core result is the sum of the conditioned operands modulo 2^16. Nothing reports overflow or carry-out, so 0xFFFF plus 1 gives 0x0000.
- R5: With `add_sel`=0, the core result is the bitwise AND of the conditioned operands.
- R6: When `neg_res` is 1, the core result is bitwise inverted before it reaches `res`.
- R7: `is_zero` is 1 exactly when all 16 bits of `res` are 0.
- R8: `is_neg` is 1 exactly when bit 15 of the final `res` is 1. This is taken after the output inversion.
- R9: The following control words, in {clr_a, neg_a, clr_b, neg_b, add_sel, neg_res} order, give the listed results:
  - 101010 gives 0, 111111 gives 1, 111010 gives -1.
  - 001100 gives A, 110000 gives B, 001101 gives NOT A, 110001 gives NOT B.
  - 001111 gives -A, 110011 gives -B.
  - 011111 gives A+1, 110111 gives B+1, 001110 gives A-1, 110010 gives B-1.
  - 000010 gives A+B, 010011 gives A-B, 000111 gives B-A.
  - 000000 gives A AND B, 010101 gives A OR B.
- R10: The parameter that picks the ripple or the prefix adder does not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 16 | Operand A |
| b_in | input | 16 | Operand B |
| clr_a | input | 1 | Clear operand A |
| neg_a | input | 1 | Invert operand A after the clear stage |
| clr_b | input | 1 | Clear operand B |
| neg_b | input | 1 | Invert operand B after the clear stage |
| add_sel | input | 1 | 1 selects addition, 0 selects bitwise AND |
| neg_res | input | 1 | Invert the core result |
| res | output | 16 | Final result |
| is_zero | output | 1 | Result is zero |
| is_neg | output | 1 | Result bit 15 is set |

## Verification
The zero flag and the wrapping adder can act on the same evaluation. This happens when the sum overflows to exactly zero: operands 0xFFFF and 0x0001 with control 000010, or A+1 with A at 0xFFFF. The bench judges these cases by requiring `res` to be 0x0000 with `is_zero` high and `is_neg` low, and by seeing no carry anywhere. The negative flag and the output inversion also meet on one evaluation, for example -A with A=1. There the flag must follow bit 15 after the inversion, not before it.

// File: rtl/palu_pkg.sv
package palu_pkg;

    typedef enum logic {
        ADDER_RIPPLE = 1'b0,
        ADDER_PREFIX = 1'b1
    } adder_arch_e;

    typedef struct packed {
        logic clr_a;
        logic neg_a;
        logic clr_b;
        logic neg_b;
        logic add_sel;
        logic neg_res;
    } palu_ctl_t;

endpackage

// File: rtl/palu_operand.sv
module palu_operand #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw,
    input  logic         clr,
    input  logic         neg,
    output logic [W-1:0] cond
);
    logic [W-1:0] cleared;

    // Clear stage first, inversion second.
    always_comb begin
        cleared = clr ? '0 : raw;
        cond    = neg ? ~cleared : cleared;
    end
endmodule

// File: rtl/palu_core.sv
module palu_core
    import palu_pkg::*;
#(
    parameter int          W    = 16,
    parameter adder_arch_e ARCH = ADDER_PREFIX
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         add_sel,
    output logic [W-1:0] core
);
    localparam int LVLS = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0] sum;

    generate
        if (ARCH == ADDER_RIPPLE) begin : g_ripple
            always_comb begin
                logic c;
                c = 1'b0;
                for (int i = 0; i < W; i++) begin
                    sum[i] = opa[i] ^ opb[i] ^ c;
                    c      = (opa[i] & opb[i]) | (c & (opa[i] ^ opb[i]));
                end
            end
        end else begin : g_prefix
            logic [W-1:0] gen_lv  [LVLS+1];
            logic [W-1:0] prop_lv [LVLS+1];
            logic [W-1:0] carry_in;

            assign gen_lv[0]  = opa & opb;
            assign prop_lv[0] = opa ^ opb;

            for (genvar k = 0; k < LVLS; k++) begin : g_lvl
                localparam int           DIST = 1 << k;
                localparam logic [W-1:0] LOWM = ~({W{1'b1}} << DIST);
                assign gen_lv[k+1]  = gen_lv[k] | (prop_lv[k] & (gen_lv[k] << DIST));
                assign prop_lv[k+1] = prop_lv[k] & ((prop_lv[k] << DIST) | LOWM);
            end

            assign carry_in = gen_lv[LVLS] << 1;
            assign sum      = prop_lv[0] ^ carry_in;
        end
    endgenerate

    always_comb begin
        core = add_sel ? sum : (opa & opb);
    end
endmodule

// File: rtl/palu_result.sv
module palu_result #(
    parameter int W = 16
) (
    input  logic [W-1:0] core,
    input  logic         neg_res,
    output logic [W-1:0] res,
    output logic         is_zero,
    output logic         is_neg
);
    always_comb begin
        res     = neg_res ? ~core : core;
        is_zero = ~|res;
        is_neg  = res[W-1];
    end
endmodule

// File: rtl/precond_alu.sv
module precond_alu
    import palu_pkg::*;
#(
    parameter int          W    = 16,
    parameter adder_arch_e ARCH = ADDER_PREFIX
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         clr_a,
    input  logic         neg_a,
    input  logic         clr_b,
    input  logic         neg_b,
    input  logic         add_sel,
    input  logic         neg_res,
    output logic [W-1:0] res,
    output logic         is_zero,
    output logic         is_neg
);
    palu_ctl_t    ctl;
    logic [W-1:0] opa_c;
    logic [W-1:0] opb_c;
    logic [W-1:0] core_r;

    assign ctl = '{clr_a: clr_a, neg_a: neg_a, clr_b: clr_b,
                   neg_b: neg_b, add_sel: add_sel, neg_res: neg_res};

    palu_operand #(.W(W)) u_opa (
        .raw(a_in), .clr(ctl.clr_a), .neg(ctl.neg_a), .cond(opa_c)
    );

    palu_operand #(.W(W)) u_opb (
        .raw(b_in), .clr(ctl.clr_b), .neg(ctl.neg_b), .cond(opb_c)
    );

    palu_core #(.W(W), .ARCH(ARCH)) u_core (
        .opa(opa_c), .opb(opb_c), .add_sel(ctl.add_sel), .core(core_r)
    );

    palu_result #(.W(W)) u_res (
        .core(core_r), .neg_res(ctl.neg_res),
        .res(res), .is_zero(is_zero), .is_neg(is_neg)
    );
endmodule

// File: rtl/precond_alu_chk.sv
module precond_alu_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] a_in,
    input logic         clr_a,
    input logic         neg_a,
    input logic         clr_b,
    input logic         neg_b,
    input logic         add_sel,
    input logic         neg_res,
    input logic [W-1:0] opa_c,
    input logic [W-1:0] opb_c,
    input logic [W-1:0] res,
    input logic         is_zero,
    input logic         is_neg
);
    always_comb begin
        // R7 / R8: the two flags can never be high together
        assert_flags_exclusive_R7: assert (!(is_zero && is_neg));
        // R1: a cleared, non-inverted operand leaves the operand stage as zero
        if (clr_a && !neg_a)
            assert_clear_a_R1: assert (opa_c == '0);
        // R3: clear plus invert gives all ones
        if (clr_b && neg_b)
            assert_clear_then_invert_R3: assert (opb_c == '1);
        // R5: an uninverted AND result only holds bits present in operand A
        if (!add_sel && !neg_res)
            assert_and_subset_R5: assert ((res & ~opa_c) == '0);
        // R2: an uncleared, inverted operand is the complement of its input
        if (!clr_a && neg_a)
            assert_invert_a_R2: assert (opa_c == ~a_in);
        // R6: the inverted AND of a zero operand is all ones
        if (clr_a && !neg_a && !add_sel && neg_res)
            assert_invert_out_R6: assert (res == '1 && is_neg);
    end
endmodule

bind precond_alu precond_alu_chk #(.W(W)) u_chk (
    .a_in(a_in), .clr_a(clr_a), .neg_a(neg_a), .clr_b(clr_b), .neg_b(neg_b),
    .add_sel(add_sel), .neg_res(neg_res), .opa_c(opa_c), .opb_c(opb_c),
    .res(res), .is_zero(is_zero), .is_neg(is_neg)
);

// File: tb/precond_alu_tb.sv
module precond_alu_tb;
    import palu_pkg::*;

    logic        clk = 1'b0;
    logic [15:0] a, b;
    logic [5:0]  cw;
    logic [15:0] res_p, res_r;
    logic        zr_p, ng_p, zr_r, ng_r;
    int          n_tests = 0;
    int          n_fail  = 0;
    int          cycles  = 0;
    bit          done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    precond_alu #(.W(16), .ARCH(ADDER_PREFIX)) u_dut (
        .a_in(a), .b_in(b), .clr_a(cw[5]), .neg_a(cw[4]), .clr_b(cw[3]),
        .neg_b(cw[2]), .add_sel(cw[1]), .neg_res(cw[0]),
        .res(res_p), .is_zero(zr_p), .is_neg(ng_p)
    );

    precond_alu #(.W(16), .ARCH(ADDER_RIPPLE)) u_rip (
        .a_in(a), .b_in(b), .clr_a(cw[5]), .neg_a(cw[4]), .clr_b(cw[3]),
        .neg_b(cw[2]), .add_sel(cw[1]), .neg_res(cw[0]),
        .res(res_r), .is_zero(zr_r), .is_neg(ng_r)
    );

    // Reference from the stage rules (R1..R8)
    function automatic logic [17:0] rule_ref(input logic [5:0] c,
                                             input logic [15:0] x, input logic [15:0] y);
        logic [15:0] xa, yb, o;
        xa = c[5] ? 16'h0 : x;  xa = c[4] ? ~xa : xa;
        yb = c[3] ? 16'h0 : y;  yb = c[2] ? ~yb : yb;
        o  = c[1] ? 16'(xa + yb) : (xa & yb);
        o  = c[0] ? ~o : o;
        return {o == 16'h0, o[15], o};
    endfunction

    // Arithmetic meaning of the listed encodings (R9)
    function automatic logic [15:0] meaning(input int idx, input logic [15:0] x,
                                            input logic [15:0] y);
        case (idx)
            0: return 16'h0000;   1: return 16'h0001;   2: return 16'hFFFF;
            3: return x;          4: return y;          5: return ~x;
            6: return ~y;         7: return 16'(-x);    8: return 16'(-y);
            9: return 16'(x + 1); 10: return 16'(y + 1); 11: return 16'(x - 1);
            12: return 16'(y - 1); 13: return 16'(x + y); 14: return 16'(x - y);
            15: return 16'(y - x); 16: return x & y;    default: return x | y;
        endcase
    endfunction

    function automatic logic [5:0] code(input int idx);
        case (idx)
            0: return 6'b101010;  1: return 6'b111111;  2: return 6'b111010;
            3: return 6'b001100;  4: return 6'b110000;  5: return 6'b001101;
            6: return 6'b110001;  7: return 6'b001111;  8: return 6'b110011;
            9: return 6'b011111;  10: return 6'b110111; 11: return 6'b001110;
            12: return 6'b110010; 13: return 6'b000010; 14: return 6'b010011;
            15: return 6'b000111; 16: return 6'b000000; default: return 6'b010101;
        endcase
    endfunction

    task automatic apply(input logic [5:0] c, input logic [15:0] x, input logic [15:0] y);
        cw = c; a = x; b = y;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cw=%b a=%h b=%h actual=%h expected=%h", req, cw, a, b, act, exp);
        end
    endtask

    task automatic t_baseline();
        apply(6'b000000, 16'h0, 16'h0);               // R5 AND of zeros, R7
        check("R7", {zr_p, ng_p, res_p}, {1'b1, 1'b0, 16'h0});
        apply(6'b001100, 16'h8001, 16'h1234);         // R8 pass A through
        check("R8", {zr_p, ng_p, res_p}, {1'b0, 1'b1, 16'h8001});
    endtask

    task automatic t_stages();
        apply(6'b100010, 16'hBEEF, 16'h0042);         // R1 cleared A in a sum
        check("R1", {zr_p, ng_p, res_p}, {1'b0, 1'b0, 16'h0042});
        apply(6'b010000, 16'h0F0F, 16'hFFFF);         // R2 inverted A AND ones
        check("R2", {zr_p, ng_p, res_p}, {1'b0, 1'b1, 16'hF0F0});
        apply(6'b111100, 16'h1357, 16'h2468);         // R3 both forced to ones
        check("R3", {zr_p, ng_p, res_p}, {1'b0, 1'b1, 16'hFFFF});
        apply(6'b000000, 16'hF0F0, 16'h3C3C);         // R5
        check("R5", {zr_p, ng_p, res_p}, {1'b0, 1'b0, 16'h3030});
        apply(6'b000001, 16'hF0F0, 16'h3C3C);         // R6
        check("R6", {zr_p, ng_p, res_p}, {1'b0, 1'b1, 16'hCFCF});
    endtask

    task automatic t_wrap();
        apply(6'b000010, 16'hFFFF, 16'h0001);         // R4 wraps to zero, R7
        check("R4", {zr_p, ng_p, res_p}, {1'b1, 1'b0, 16'h0000});
        apply(6'b000010, 16'h7FFF, 16'h0001);         // R4 / R8 into sign bit
        check("R4", {zr_p, ng_p, res_p}, {1'b0, 1'b1, 16'h8000});
        apply(6'b011111, 16'hFFFF, 16'h5555);         // R9 A+1 at the top wraps
        check("R9", {zr_p, ng_p, res_p}, {1'b1, 1'b0, 16'h0000});
        apply(6'b001111, 16'h0001, 16'h0);            // R8 -A, flag after inversion
        check("R8", {zr_p, ng_p, res_p}, {1'b0, 1'b1, 16'hFFFF});
        apply(6'b010011, 16'h0007, 16'h0005);         // R9 A-B small example
        check("R9", {zr_p, ng_p, res_p}, {1'b0, 1'b0, 16'h0002});
    endtask

    task automatic t_encodings();
        for (int r = 0; r < 40; r++) begin
            logic [15:0] x, y, m;
            x = 16'($urandom); y = 16'($urandom);
            if (r == 0) begin x = 16'h0; y = 16'hFFFF; end
            if (r == 1) begin x = 16'h8000; y = 16'h8000; end
            for (int k = 0; k < 18; k++) begin
                apply(code(k), x, y);
                m = meaning(k, x, y);
                check("R9", {zr_p, ng_p, res_p}, {m == 16'h0, m[15], m});
            end
        end
    endtask

    task automatic t_all_controls();
        for (int r = 0; r < 30; r++) begin
            logic [15:0] x, y;
            x = 16'($urandom); y = 16'($urandom);
            for (int c = 0; c < 64; c++) begin
                apply(6'(c), x, y);
                check("R7", {zr_p, ng_p, res_p}, rule_ref(6'(c), x, y));
                check("R10", {zr_r, ng_r, res_r}, {zr_p, ng_p, res_p});
            end
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cw = 6'b0; a = 16'h0; b = 16'h0;
        @(negedge clk);
        t_baseline();
        t_stages();
        t_wrap();
        t_encodings();
        t_all_controls();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule